// File: doc/BRIEF.md
# Serial Flash Software Command Engine

This block issues one free-form command to a serial NOR flash sitting on one of several chip-select banks. Software first places up to four outgoing bytes in a transmit word. It then writes a single control word that carries four things: how many bytes to send, how many bytes to receive, which bank to address, and a go bit. If the controller is in software mode, the engine selects the bank and clocks the outgoing bytes out in SPI mode 0. It then clocks in the requested number of reply bytes and places them in a receive word.

Once the last bit has moved, the chip select is held inactive for a programmable deselect gap. After that gap the engine raises a sticky transfer-finished flag. The flag drives an interrupt when the enable bit in the most recently written control word is set. Software clears the flag with a status-clear pulse, which stands for writing zero to the status register.

Register decoding and serial clock division sit outside this block. It receives already-decoded fields and a serial-clock enable. Each enable tick marks one half period of the serial clock.

Top module: `sfe_cmd_engine`

## Requirements
- R1: After reset every chip select is high, sck is low, busy, xfer_done and irq are low, and rx_word is zero.
- R2: A transfer starts only on a cycle with ctl_wr high, go bit ctl_word[7] set and sw_mode high; a go request while sw_mode is low does nothing.
- R3: The byte count to send is ctl_word[2:0]. Bytes leave starting with tx_word[7:0], then [15:8], [23:16] and [31:24], each most significant bit first. sck idles low, mosi changes only after a falling sck edge, and miso is sampled on the rising edge.
- R4: The byte count to receive is ctl_word[6:4]. Received bytes are packed so that the first byte lands in the highest occupied byte of rx_word. All bits above the received bytes read as zero. rx_word updates when the transfer finishes.
- R5: The bank number is ctl_word[13:12]. cs_n[bank] is low while bits move, provided bank_en[bank] is 1. If that enable bit is 0, no chip select goes low. At most one chip select is ever low.
- R6: After the last bit, all chip selects stay high for (dsel+1) serial clock periods, which is 2*(dsel+1) sclk_en ticks, before the transfer counts as finished.
- R7: xfer_done sets when a transfer finishes and holds until a stat_clr pulse. irq equals xfer_done AND the interrupt-enable bit ctl_word[8] of the most recent control write.
- R8: A go request that arrives while a transfer is in progress is ignored and does not alter the running transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_en | input | 1 | Half-period tick of the serial clock |
| sw_mode | input | 1 | Software mode; enables the go bit |
| bank_en | input | 4 | Per-bank enable mask |
| dsel | input | 4 | Deselect gap field (periods minus one) |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_word | input | 14 | Control word: lengths, go, irq enable, bank |
| tx_word | input | 32 | Outgoing bytes, byte 0 sent first |
| stat_clr | input | 1 | Clears the transfer-finished flag |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the flash |
| cs_n | output | 4 | Active-low chip selects, one per bank |
| rx_word | output | 32 | Received bytes |
| xfer_done | output | 1 | Sticky transfer-finished flag |
| irq | output | 1 | Transfer-finished interrupt |
| busy | output | 1 | Transfer or deselect gap in progress |

## Verification
The bench builds the engine with its default parameters: four bytes per direction, four banks and a 4-bit deselect field. With these values it can exercise a full 32-bit receive word, a four-byte erase-style command and a read-ID exchange. It can also address the top bank and a disabled bank. Two different deselect settings (6 and 2) confirm the gap length is counted from the field rather than fixed.

// File: rtl/sfe_pkg.sv
// Shared definitions for the serial flash command engine.
// Assumes: field positions are fixed by the software-visible control word.
package sfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } sfe_state_t;

    localparam int CTL_TXL_LSB  = 0;
    localparam int CTL_RXL_LSB  = 4;
    localparam int CTL_GO_BIT   = 7;
    localparam int CTL_IE_BIT   = 8;
    localparam int CTL_BANK_LSB = 12;
endpackage

// File: rtl/sfe_ctrl.sv
// Sequencer: walks the bit slots of a transfer in half-period steps and
// then times the deselect gap.
// Assumes: start is only raised while busy is low; tot_bits may be zero.
module sfe_ctrl
    import sfe_pkg::*;
#(
    parameter int BIT_W  = 7,
    parameter int DSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_en,
    input  logic              start,
    input  logic [BIT_W-1:0]  tot_bits,
    input  logic [DSEL_W-1:0] dsel,
    output logic              busy,
    output logic              shifting,
    output logic              sck,
    output logic              rise,
    output logic              fall,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              done
);
    localparam int GAP_W = DSEL_W + 1;

    sfe_state_t        state;
    logic              ph;
    logic [BIT_W-1:0]  bit_q;
    logic [BIT_W-1:0]  tot_q;
    logic [DSEL_W-1:0] dsel_q;
    logic [GAP_W-1:0]  gap_q;
    logic [GAP_W-1:0]  gap_end;

    // gap lasts 2*(dsel+1) ticks, the counter ends at 2*dsel+1
    assign gap_end = {dsel_q, 1'b1};

    // state, phase, bit and gap counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ph     <= 1'b0;
            bit_q  <= '0;
            tot_q  <= '0;
            dsel_q <= '0;
            gap_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    tot_q  <= tot_bits;
                    dsel_q <= dsel;
                    bit_q  <= '0;
                    ph     <= 1'b0;
                    gap_q  <= '0;
                    state  <= (tot_bits == '0) ? ST_GAP : ST_SHIFT;
                end
                ST_SHIFT: if (sclk_en) begin
                    if (!ph) begin
                        ph <= 1'b1;
                    end else begin
                        ph <= 1'b0;
                        if (bit_q == tot_q - BIT_W'(1)) begin
                            state <= ST_GAP;
                            gap_q <= '0;
                        end else begin
                            bit_q <= bit_q + BIT_W'(1);
                        end
                    end
                end
                ST_GAP: if (sclk_en) begin
                    if (gap_q == gap_end) state <= ST_IDLE;
                    else                  gap_q <= gap_q + GAP_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // decoded strobes for the data path
    always_comb begin
        busy     = (state != ST_IDLE);
        shifting = (state == ST_SHIFT);
        sck      = shifting && ph;
        rise     = shifting && sclk_en && !ph;
        fall     = shifting && sclk_en && ph;
        bit_idx  = bit_q;
        done     = (state == ST_GAP) && sclk_en && (gap_q == gap_end);
    end
endmodule

// File: rtl/sfe_shift.sv
// Data path: serialises the transmit word byte 0 first, MSB first, and
// assembles received bits MSB first into a zero-cleared register.
// Assumes: load coincides with the transfer start; rise/fall come from sfe_ctrl.
module sfe_shift #(
    parameter int BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [8*BYTES-1:0] tx_word,
    input  logic            rise,
    input  logic            fall,
    input  logic            tx_phase,
    input  logic            rx_phase,
    input  logic            miso,
    output logic            mosi,
    output logic [8*BYTES-1:0] rx_data
);
    localparam int DW = 8 * BYTES;

    logic [DW-1:0] swapped;
    logic [DW-1:0] tx_ser;

    // reverse byte order so byte 0 leaves first from the top
    for (genvar b = 0; b < BYTES; b++) begin : g_swap
        assign swapped[DW-1-8*b -: 8] = tx_word[8*b +: 8];
    end

    // transmit and receive shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ser  <= '0;
            rx_data <= '0;
        end else if (load) begin
            tx_ser  <= swapped;
            rx_data <= '0;
        end else begin
            if (fall && tx_phase) tx_ser  <= {tx_ser[DW-2:0], 1'b0};
            if (rise && rx_phase) rx_data <= {rx_data[DW-2:0], miso};
        end
    end

    // serial output, held low outside the send phase
    assign mosi = tx_phase ? tx_ser[DW-1] : 1'b0;
endmodule

// File: rtl/sfe_csdec.sv
// Chip-select decoder: one active-low select per bank, gated by its enable.
// Assumes: bank is stable for the whole transfer.
module sfe_csdec #(
    parameter int BANKS  = 4,
    parameter int BANK_W = 2
) (
    input  logic              active,
    input  logic [BANK_W-1:0] bank,
    input  logic [BANKS-1:0]  bank_en,
    output logic [BANKS-1:0]  cs_n
);
    // one comparator per bank
    for (genvar i = 0; i < BANKS; i++) begin : g_cs
        assign cs_n[i] = !(active && (bank == BANK_W'(i)) && bank_en[i]);
    end
endmodule

// File: rtl/sfe_cmd_engine.sv
// Top: accepts a control-word write, latches lengths and bank, runs the
// sequencer and data path, and keeps the sticky finish flag and interrupt.
// Assumes: register decoding and serial clock division live outside.
module sfe_cmd_engine
    import sfe_pkg::*;
#(
    parameter int BYTES  = 4,
    parameter int BANKS  = 4,
    parameter int DSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_en,
    input  logic              sw_mode,
    input  logic [BANKS-1:0]  bank_en,
    input  logic [DSEL_W-1:0] dsel,
    input  logic              ctl_wr,
    input  logic [13:0]       ctl_word,
    input  logic [8*BYTES-1:0] tx_word,
    input  logic              stat_clr,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [BANKS-1:0]  cs_n,
    output logic [8*BYTES-1:0] rx_word,
    output logic              xfer_done,
    output logic              irq,
    output logic              busy
);
    localparam int DW     = 8 * BYTES;
    localparam int LEN_W  = 3;
    localparam int BANK_W = $clog2(BANKS);
    localparam int BIT_W  = $clog2(16 * BYTES + 1);

    logic [LEN_W-1:0]  txl_raw, rxl_raw, txl_c, rxl_c, txl_q;
    logic [BANK_W-1:0] bank_q;
    logic [BIT_W-1:0]  tot_bits, bit_idx;
    logic              start, shifting, rise, fall, done;
    logic              tx_phase, rx_phase;
    logic              ie_q, tff_q;
    logic [DW-1:0]     rx_data;
    logic              ctl_unused;

    assign ctl_unused = ^{ctl_word[3], ctl_word[11:9]};

    // decode and clamp the length fields
    always_comb begin
        txl_raw  = ctl_word[CTL_TXL_LSB +: LEN_W];
        rxl_raw  = ctl_word[CTL_RXL_LSB +: LEN_W];
        txl_c    = (txl_raw > LEN_W'(BYTES)) ? LEN_W'(BYTES) : txl_raw;
        rxl_c    = (rxl_raw > LEN_W'(BYTES)) ? LEN_W'(BYTES) : rxl_raw;
        tot_bits = (BIT_W'(txl_c) + BIT_W'(rxl_c)) << 3;
        start    = ctl_wr && ctl_word[CTL_GO_BIT] && sw_mode && !busy;
        tx_phase = shifting && (bit_idx < (BIT_W'(txl_q) << 3));
        rx_phase = shifting && !tx_phase;
    end

    // per-transfer fields, interrupt enable, finish flag, receive word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txl_q   <= '0;
            bank_q  <= '0;
            ie_q    <= 1'b0;
            tff_q   <= 1'b0;
            rx_word <= '0;
        end else begin
            if (ctl_wr) ie_q <= ctl_word[CTL_IE_BIT];
            if (start) begin
                txl_q  <= txl_c;
                bank_q <= ctl_word[CTL_BANK_LSB +: BANK_W];
            end
            if (done) begin
                tff_q   <= 1'b1;
                rx_word <= rx_data;
            end else if (stat_clr) begin
                tff_q <= 1'b0;
            end
        end
    end

    assign xfer_done = tff_q;
    assign irq       = tff_q && ie_q;

    sfe_ctrl #(.BIT_W(BIT_W), .DSEL_W(DSEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .start(start),
        .tot_bits(tot_bits), .dsel(dsel), .busy(busy), .shifting(shifting),
        .sck(sck), .rise(rise), .fall(fall), .bit_idx(bit_idx), .done(done)
    );

    sfe_shift #(.BYTES(BYTES)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(start), .tx_word(tx_word),
        .rise(rise), .fall(fall), .tx_phase(tx_phase), .rx_phase(rx_phase),
        .miso(miso), .mosi(mosi), .rx_data(rx_data)
    );

    sfe_csdec #(.BANKS(BANKS), .BANK_W(BANK_W)) u_cs (
        .active(shifting), .bank(bank_q), .bank_en(bank_en), .cs_n(cs_n)
    );
endmodule

// File: rtl/sfe_chk.sv
// Checker for sfe_cmd_engine: port-level protocol properties.
// Assumes: attached through the bind below.
module sfe_chk #(
    parameter int BANKS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_en,
    input logic             sw_mode,
    input logic             ctl_wr,
    input logic [13:0]      ctl_word,
    input logic             stat_clr,
    input logic             sck,
    input logic [BANKS-1:0] cs_n,
    input logic             xfer_done,
    input logic             irq,
    input logic             busy
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && (&cs_n)));
    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(ctl_wr) && $past(ctl_word[7]) && $past(sw_mode)));
    // R3
    sck_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck) |-> $past(sclk_en));
    // R5
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R6
    gap_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ((&cs_n) && $past(&cs_n)));
    // R7
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> xfer_done);
    // R7
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !busy) |=> !xfer_done);
endmodule

bind sfe_cmd_engine sfe_chk #(.BANKS(BANKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .sw_mode(sw_mode),
    .ctl_wr(ctl_wr), .ctl_word(ctl_word), .stat_clr(stat_clr), .sck(sck),
    .cs_n(cs_n), .xfer_done(xfer_done), .irq(irq), .busy(busy)
);

// File: tb/sim_sfe_cmd_engine.sv
`timescale 1ns/1ps
module sim_sfe_cmd_engine;
    logic        clk = 0, rst_n = 0, sclk_en = 0, sw_mode = 1;
    logic [3:0]  bank_en = 4'hF, dsel = 4'd6;
    logic        ctl_wr = 0, stat_clr = 0;
    logic [13:0] ctl_word = '0;
    logic [31:0] tx_word = '0;
    logic        sck, mosi, xfer_done, irq, busy, miso;
    logic [3:0]  cs_n;
    logic [31:0] rx_word;

    int errors = 0, checks = 0;

    // flash model / monitor state
    logic        mon_clr = 0;
    logic [63:0] pat_init = '0, pat = '0;
    logic [63:0] mosi_cap = '0;
    int          rises = 0, gapc = 0;
    logic [3:0]  cs_seen = '0;
    logic        prev_sck = 0;

    always #5 clk = ~clk;

    sfe_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .sw_mode(sw_mode),
        .bank_en(bank_en), .dsel(dsel), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
        .tx_word(tx_word), .stat_clr(stat_clr), .miso(miso), .sck(sck),
        .mosi(mosi), .cs_n(cs_n), .rx_word(rx_word), .xfer_done(xfer_done),
        .irq(irq), .busy(busy)
    );

    assign miso = pat[63];

    // serial clock enable toggles every core cycle
    initial forever begin
        @(posedge clk); #1;
        sclk_en = ~sclk_en;
    end

    // flash model: capture mosi on rising sck, advance reply on falling sck
    always @(negedge clk) begin
        prev_sck <= sck;
        if (mon_clr) begin
            pat <= pat_init; mosi_cap <= '0; rises <= 0;
            cs_seen <= '0; gapc <= 0;
        end else begin
            if (sck && !prev_sck) begin
                mosi_cap <= {mosi_cap[62:0], mosi};
                rises    <= rises + 1;
            end
            if (!sck && prev_sck) pat <= pat << 1;
            cs_seen <= cs_seen | ~cs_n;
            if (sck) gapc <= 0;
            else if (busy && sclk_en) gapc <= gapc + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] mk_ctl(input int txl, input int rxl,
                                           input int bank, input bit go, input bit ie);
        logic [13:0] w = '0;
        w[2:0]   = 3'(txl);
        w[6:4]   = 3'(rxl);
        w[7]     = go;
        w[8]     = ie;
        w[13:12] = 2'(bank);
        return w;
    endfunction

    // reply pattern: ones during send slots, then reply bytes MSB first
    function automatic logic [63:0] mk_pat(input int txl, input int rxl, input logic [31:0] rxv);
        logic [63:0] p;
        p = {rxv, 32'h0} << (8 * (4 - rxl));
        p = p >> (8 * txl);
        p = p | ~({64{1'b1}} >> (8 * txl));
        return p;
    endfunction

    task automatic pulse_ctl(input logic [13:0] w);
        @(posedge clk); #1;
        ctl_word = w; ctl_wr = 1;
        @(posedge clk); #1;
        ctl_wr = 0;
    endtask

    task automatic clear_flag();
        @(posedge clk); #1; stat_clr = 1;
        @(posedge clk); #1; stat_clr = 0;
    endtask

    task automatic run_xfer(input logic [31:0] tx, input int txl, input int rxl,
                            input int bank, input bit ie, input logic [31:0] rxv);
        @(posedge clk); #1;
        mon_clr = 1; pat_init = mk_pat(txl, rxl, rxv); tx_word = tx;
        @(posedge clk); #1;
        mon_clr = 0;
        pulse_ctl(mk_ctl(txl, rxl, bank, 1'b1, ie));
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 cs_n", 64'(cs_n), 64'hF);
        check("R1 sck/busy/done/irq", {60'h0, sck, busy, xfer_done, irq}, 64'h0);
        check("R1 rx_word", 64'(rx_word), 64'h0);
    endtask

    task automatic t_read_id();
        dsel = 4'd6;
        run_xfer(32'h0000_009F, 1, 3, 1, 1'b1, 32'h00C2_2015);
        check("R3 opcode bits", 64'(mosi_cap[31:24]), 64'h9F);
        check("R3 bit count", 64'(rises), 64'd32);
        check("R4 id packing", 64'(rx_word), 64'h00C2_2015);
        check("R5 bank1 select", 64'(cs_seen), 64'h2);
        check("R6 gap dsel6", 64'(gapc), 64'd14);
        check("R7 done+irq", {62'h0, xfer_done, irq}, 64'h3);
        pulse_ctl(14'h0);
        @(negedge clk);
        check("R7 irq follows ie", {62'h0, xfer_done, irq}, 64'h2);
        clear_flag();
        @(negedge clk);
        check("R7 flag cleared", 64'(xfer_done), 64'h0);
    endtask

    task automatic t_erase();
        dsel = 4'd2;
        run_xfer(32'h5634_12D8, 4, 0, 3, 1'b0, 32'h0);
        check("R3 erase frame", 64'(mosi_cap[31:0]), 64'hD812_3456);
        check("R4 no rx zero", 64'(rx_word), 64'h0);
        check("R5 bank3 select", 64'(cs_seen), 64'h8);
        check("R6 gap dsel2", 64'(gapc), 64'd6);
        check("R7 done no irq", {62'h0, xfer_done, irq}, 64'h2);
        clear_flag();
        dsel = 4'd6;
    endtask

    task automatic t_full_rx();
        run_xfer(32'h0, 0, 4, 0, 1'b0, 32'hA51C_3E07);
        check("R4 four byte rx", 64'(rx_word), 64'hA51C_3E07);
        check("R5 bank0 select", 64'(cs_seen), 64'h1);
        clear_flag();
        run_xfer(32'h0000_0005, 1, 2, 2, 1'b0, 32'h0000_BEEF);
        check("R4 two byte rx upper zero", 64'(rx_word), 64'h0000_BEEF);
        clear_flag();
    endtask

    task automatic t_bank_off();
        bank_en = 4'b1101;
        run_xfer(32'h0000_0006, 1, 0, 1, 1'b0, 32'h0);
        check("R5 disabled bank no cs", 64'(cs_seen), 64'h0);
        check("R5 disabled bank still done", 64'(xfer_done), 64'h1);
        bank_en = 4'hF;
        clear_flag();
    endtask

    task automatic t_sw_off();
        sw_mode = 0;
        @(posedge clk); #1; mon_clr = 1;
        @(posedge clk); #1; mon_clr = 0;
        pulse_ctl(mk_ctl(1, 1, 0, 1'b1, 1'b1));
        repeat (60) @(negedge clk);
        check("R2 no start when sw off", {32'(rises), 28'h0, cs_seen}, 64'h0);
        check("R2 no flag when sw off", {62'h0, xfer_done, irq}, 64'h0);
        sw_mode = 1;
        pulse_ctl(14'h0);
    endtask

    task automatic t_busy_ignore();
        @(posedge clk); #1;
        mon_clr = 1; pat_init = mk_pat(1, 2, 32'h0000_1234); tx_word = 32'h0000_0003;
        @(posedge clk); #1; mon_clr = 0;
        pulse_ctl(mk_ctl(1, 2, 0, 1'b1, 1'b0));
        repeat (20) @(posedge clk);
        #1 tx_word = 32'h0000_00FF;
        pulse_ctl(mk_ctl(4, 4, 3, 1'b1, 1'b0));
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (100) @(negedge clk);
        check("R8 single transfer bits", 64'(rises), 64'd24);
        check("R8 first opcode kept", 64'(mosi_cap[23:16]), 64'h03);
        check("R8 rx of first transfer", 64'(rx_word), 64'h1234);
        check("R8 bank unchanged", 64'(cs_seen), 64'h1);
        clear_flag();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_read_id();
        t_erase();
        t_full_rx();
        t_bank_off();
        t_sw_off();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule